// File: doc/BRIEF.md
# Descriptor Ring Slot Manager

This block services two descriptor rings, one for receive and one for transmit, kept in a word-addressed memory. Both rings share one 1 KB-aligned region. Receive slots start at the region base and transmit slots start 0x200 bytes above it. Each slot holds 8 bytes in two 32-bit words. Word 0 carries a 16-bit length in bits 15:0, of which the low 12 bits are the buffer length. It also carries a spare byte in bits 23:16 and a control/status byte in bits 31:24. Word 1 holds the buffer address.

Software fills slots, sets the ownership bit and writes the prompt register. The block then walks each ring from its current slot pointer. For every slot the hardware owns, it fetches the header and the buffer address. It hands them to the packet peer through a request/done handshake, writes the status back with the ownership bit cleared, and advances the pointer. Each ring's walk ends at the first slot it does not own.

When both rings have work, the engine alternates between them at slot granularity. The two slot pointers are visible at all times as 6-bit outputs.

Top module: `ring_mgr`

## Requirements
- R1: While reset is held, both slot pointers read 0, and mem_rd, mem_wr, tx_req, rx_req and txdone_irq are all 0.
- R2: A configuration write to offset 4 with data bit 0 set makes the block scan both rings. A write to offset 4 with bit 0 clear causes no memory access and no pointer change.
- R3: The ring base is loaded by byte writes. Offset 0 takes base bits 17:10, offset 1 takes bits 25:18 and offset 2 takes bits 31:26 from data bits 5:0. Base bits 9:0 are zero. Receive slot i is at byte base+8i and transmit slot i at byte base+0x200+8i. mem_addr is the byte address shifted right by 2, and word 1 of a slot follows word 0.
- R4: Offset 3 holds the ring sizes: the low nibble for receive and the high nibble for transmit. The codes 0x0, 0x1, 0x3, 0x7 and 0xF select 4, 8, 16, 32 and 64 slots. A pointer at the last slot wraps to 0.
- R5: Only slots with control bit 7 (word 0 bit 31) set are serviced. A ring's scan stops at its first slot without that bit, and the pointer stays on that slot.
- R6: For an owned slot, buf_addr equals word 1 and buf_len equals length bits 11:0. The request stays high until its done strobe arrives, and tx_req and rx_req are never high together.
- R7: Receive write-back sets the length field to rx_count saturated at 4095, with the upper 4 bits zero, and keeps the spare byte. The control byte is written as: bit 1 always set; bit 3 from rx_overflow; bit 4 when rx_count exceeds the 12-bit buffer length; bit 5 from rx_crc_err; bit 6 from rx_phy_err; all other bits 0.
- R8: Transmit write-back keeps the length field, the spare byte and control bits 6:1. It clears bit 7 and writes tx_underrun into bit 0.
- R9: txdone_irq pulses for one cycle, together with the write-back, for a transmit slot whose control bit 2 was set. It stays low otherwise.
- R10: A slot pointer moves only in the cycle after its ring's write-back, and by exactly one slot (or a wrap) per serviced slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| rx_slot | output | 6 | Receive slot pointer |
| tx_slot | output | 6 | Transmit slot pointer |
| mem_rd | output | 1 | Memory read strobe, data returns next cycle |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| buf_addr | output | 32 | Buffer address of the slot being served |
| buf_len | output | 12 | Buffer length of the slot being served |
| tx_req | output | 1 | Transmit request to the packet peer |
| tx_done | input | 1 | Transmit completion strobe |
| tx_underrun | input | 1 | Underrun flag, valid with tx_done |
| txdone_irq | output | 1 | Transmit-done interrupt pulse |
| rx_req | output | 1 | Receive request to the packet peer |
| rx_done | input | 1 | Receive completion strobe |
| rx_count | input | 16 | Bytes received, valid with rx_done |
| rx_overflow | input | 1 | Receive overflow flag |
| rx_crc_err | input | 1 | Receive CRC error flag |
| rx_phy_err | input | 1 | Receive decoder error flag |

## Verification
The embedded properties watch, on every cycle, the rules that hold regardless of memory contents. They check that only one request is active at a time and that a request holds until its done strobe. They check that every write-back clears the ownership bit and that reads and writes never overlap. They also check that the interrupt occurs only alongside a write-back, and that a pointer moves only right after a write-back, by one step or a wrap to 0. The bench scenarios are needed to show the data-dependent behaviour. That covers the exact slot addresses under two different base values, and the status bytes built from peer flags, including length saturation and the too-long comparison. It also covers preservation of the transmit control bits, wrap at 4 and at 8 slots, the scan stopping at the first slot not owned, and the prompt write that must be ignored.

// File: rtl/ring_mgr_pkg.sv
// Shared constants, state type and size decoding for the ring manager.
// Assumes 8-byte slots in a 1 KB region: 64 receive and 64 transmit slots.
package ring_mgr_pkg;
    localparam int SLOT_W    = 6;   // slot pointer width (up to 64 slots)
    localparam int BLEN_W    = 12;  // buffer length bits in the header
    localparam int WORD_W    = 32;  // memory word width
    localparam int REGION_LSB = 10; // ring region alignment (1 KB)

    // control byte positions inside header word bits 31:24
    localparam int CB_OWN     = 31;
    localparam int CB_IRQ_REQ = 26;

    // configuration register offsets
    localparam logic [2:0] OFS_BASE_A = 3'd0;
    localparam logic [2:0] OFS_BASE_B = 3'd1;
    localparam logic [2:0] OFS_BASE_C = 3'd2;
    localparam logic [2:0] OFS_SIZE   = 3'd3;
    localparam logic [2:0] OFS_PROMPT = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HDR,
        ST_CHK_HDR,
        ST_RD_BUF,
        ST_WAIT_PEER,
        ST_WRITE_BACK
    } eng_state_t;

    // Thermometer size code to index of the last slot; a malformed code
    // is rounded to its highest set bit.
    function automatic logic [SLOT_W-1:0] last_slot(input logic [3:0] code);
        logic [SLOT_W-1:0] m;
        m[0] = 1'b1;
        m[1] = 1'b1;
        m[2] = |code;
        m[3] = |code[3:1];
        m[4] = |code[3:2];
        m[5] = code[3];
        return m;
    endfunction
endpackage

// File: rtl/ring_mgr_cfg.sv
// Configuration registers: ring base bytes, size byte and prompt decode.
// Assumes byte-wide writes; offsets outside the map are ignored.
module ring_mgr_cfg
    import ring_mgr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [7:0]               cfg_wdata,
    output logic [ADDR_W-REGION_LSB-1:0] base_hi,
    output logic [3:0]               rx_size_code,
    output logic [3:0]               tx_size_code,
    output logic                     prompt
);
    localparam int BASE_W = ADDR_W - REGION_LSB;

    logic [BASE_W-1:0] base_q;
    logic [7:0]        size_q;

    // Purpose: capture byte writes into base and size registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                OFS_BASE_A: base_q[7:0]        <= cfg_wdata;
                OFS_BASE_B: base_q[15:8]       <= cfg_wdata;
                OFS_BASE_C: base_q[BASE_W-1:16] <= cfg_wdata[BASE_W-17:0];
                OFS_SIZE:   size_q             <= cfg_wdata;
                default:    ;
            endcase
        end
    end

    // Purpose: one-cycle scan request from a prompt write with bit 0 set.
    always_comb begin
        prompt = cfg_we && (cfg_addr == OFS_PROMPT) && cfg_wdata[0];
    end

    assign base_hi      = base_q;
    assign rx_size_code = size_q[3:0];
    assign tx_size_code = size_q[7:4];
endmodule

// File: rtl/ring_mgr_ptr.sv
// Slot pointer for one ring: advances on request and wraps after the
// last slot of the programmed size. Assumes the size may change at any
// time, so any pointer at or beyond the last slot wraps.
module ring_mgr_ptr
    import ring_mgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [3:0]        size_code,
    output logic [SLOT_W-1:0] ptr
);
    logic [SLOT_W-1:0] last;

    // Purpose: decode the size code to the last slot index.
    always_comb begin
        last = last_slot(size_code);
    end

    // Purpose: step or wrap the pointer after a serviced slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr >= last) ? '0 : ptr + 1'b1;
    end

    // R4: a pointer at the last slot wraps to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr >= last) |=> (ptr == '0));
    // R10: otherwise it moves by exactly one slot
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr < last) |=> (ptr == $past(ptr) + 1'b1));
    // R10: without an advance the pointer holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/ring_mgr_engine.sv
// Slot engine shared by both rings. It reads the header word, checks
// ownership, reads the buffer address, runs the peer handshake and writes
// the status back. Assumes memory read data arrives one cycle after mem_rd.
// Rings alternate at slot granularity when both have pending work.
module ring_mgr_engine
    import ring_mgr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prompt,
    input  logic [ADDR_W-REGION_LSB-1:0] base_hi,
    input  logic [SLOT_W-1:0]            rx_ptr,
    input  logic [SLOT_W-1:0]            tx_ptr,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [ADDR_W-3:0]            mem_addr,
    output logic [WORD_W-1:0]            mem_wdata,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic [WORD_W-1:0]            buf_addr,
    output logic [BLEN_W-1:0]            buf_len,
    output logic                         tx_req,
    input  logic                         tx_done,
    input  logic                         tx_underrun,
    output logic                         txdone_irq,
    output logic                         rx_req,
    input  logic                         rx_done,
    input  logic [CNT_W-1:0]             rx_count,
    input  logic                         rx_overflow,
    input  logic                         rx_crc_err,
    input  logic                         rx_phy_err,
    output logic                         rx_adv,
    output logic                         tx_adv
);
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'((1 << BLEN_W) - 1);

    eng_state_t        state;
    logic              sel_tx;
    logic              prefer_tx;
    logic              rx_pend;
    logic              tx_pend;
    logic [WORD_W-1:0] hdr_q;
    logic [WORD_W-1:0] baddr_q;
    logic [WORD_W-1:0] wb_q;
    logic [SLOT_W-1:0] cur_ptr;
    logic              owned;
    logic [BLEN_W-1:0] rx_len_sat;
    logic [7:0]        rx_ctrl;
    logic [7:0]        tx_ctrl;

    // Purpose: pick the slot pointer of the ring being served.
    always_comb begin
        cur_ptr = sel_tx ? tx_ptr : rx_ptr;
        owned   = mem_rdata[CB_OWN];
    end

    // Purpose: build receive and transmit status bytes from peer results.
    always_comb begin
        rx_len_sat = (rx_count > LEN_MAX) ? BLEN_W'(LEN_MAX) : rx_count[BLEN_W-1:0];
        rx_ctrl    = {1'b0, rx_phy_err, rx_crc_err,
                      (rx_count > CNT_W'(hdr_q[BLEN_W-1:0])),
                      rx_overflow, 1'b0, 1'b1, 1'b0};
        tx_ctrl    = {1'b0, hdr_q[30:25], tx_underrun};
    end

    // Purpose: step through the per-slot sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel_tx    <= 1'b0;
            prefer_tx <= 1'b0;
            hdr_q     <= '0;
            baddr_q   <= '0;
            wb_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rx_pend || tx_pend) begin
                        sel_tx <= tx_pend && (!rx_pend || prefer_tx);
                        state  <= ST_RD_HDR;
                    end
                end
                ST_RD_HDR:  state <= ST_CHK_HDR;
                ST_CHK_HDR: begin
                    if (owned) begin
                        hdr_q <= mem_rdata;
                        state <= ST_RD_BUF;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_RD_BUF: begin
                    baddr_q <= mem_rdata;
                    state   <= ST_WAIT_PEER;
                end
                ST_WAIT_PEER: begin
                    if (sel_tx && tx_done) begin
                        wb_q  <= {tx_ctrl, hdr_q[23:0]};
                        state <= ST_WRITE_BACK;
                    end else if (!sel_tx && rx_done) begin
                        wb_q  <= {rx_ctrl, hdr_q[23:16],
                                  {(16-BLEN_W){1'b0}}, rx_len_sat};
                        state <= ST_WRITE_BACK;
                    end
                end
                ST_WRITE_BACK: begin
                    prefer_tx <= !sel_tx;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: track rings with work; a prompt wins over a stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend <= 1'b0;
            tx_pend <= 1'b0;
        end else if (prompt) begin
            rx_pend <= 1'b1;
            tx_pend <= 1'b1;
        end else if (state == ST_CHK_HDR && !owned) begin
            if (sel_tx) tx_pend <= 1'b0;
            else        rx_pend <= 1'b0;
        end
    end

    // Purpose: drive memory, handshake and pointer strobes from the state.
    always_comb begin
        mem_rd     = (state == ST_RD_HDR) || (state == ST_CHK_HDR && owned);
        mem_wr     = (state == ST_WRITE_BACK);
        mem_addr   = {base_hi, sel_tx, cur_ptr, (state == ST_CHK_HDR)};
        mem_wdata  = wb_q;
        buf_addr   = baddr_q;
        buf_len    = hdr_q[BLEN_W-1:0];
        tx_req     = (state == ST_WAIT_PEER) && sel_tx;
        rx_req     = (state == ST_WAIT_PEER) && !sel_tx;
        txdone_irq = (state == ST_WRITE_BACK) && sel_tx && hdr_q[CB_IRQ_REQ];
        tx_adv     = (state == ST_WRITE_BACK) && sel_tx;
        rx_adv     = (state == ST_WRITE_BACK) && !sel_tx;
    end

    // R6: never both requests at once
    a_r6_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && rx_req));
    // R6: requests hold until their done strobe
    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> tx_req);
    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_done) |=> rx_req);
    // R5: every write-back releases ownership
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[CB_OWN]);
    // R3: reads and writes never share a cycle
    a_r3_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R9: the interrupt only comes with a write-back
    a_r9_irq_wb: assert property (@(posedge clk) disable iff (!rst_n)
        txdone_irq |-> mem_wr);
endmodule

// File: rtl/ring_mgr.sv
// Descriptor ring slot manager top: configuration registers, one slot
// pointer per ring and the shared slot engine. Assumes a memory that
// returns read data one cycle after mem_rd.
module ring_mgr
    import ring_mgr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [5:0]        rx_slot,
    output logic [5:0]        tx_slot,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       buf_addr,
    output logic [11:0]       buf_len,
    output logic              tx_req,
    input  logic              tx_done,
    input  logic              tx_underrun,
    output logic              txdone_irq,
    output logic              rx_req,
    input  logic              rx_done,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_overflow,
    input  logic              rx_crc_err,
    input  logic              rx_phy_err
);
    localparam int BASE_W = ADDR_W - REGION_LSB;

    logic [BASE_W-1:0] base_hi;
    logic [3:0]        size_code [2];
    logic [1:0]        adv;
    logic [SLOT_W-1:0] ptr [2];
    logic              prompt;

    ring_mgr_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .base_hi      (base_hi),
        .rx_size_code (size_code[0]),
        .tx_size_code (size_code[1]),
        .prompt       (prompt)
    );

    // index 0 is the receive ring, index 1 the transmit ring
    for (genvar g = 0; g < 2; g++) begin : g_ring
        ring_mgr_ptr u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (adv[g]),
            .size_code (size_code[g]),
            .ptr       (ptr[g])
        );
    end

    ring_mgr_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .prompt      (prompt),
        .base_hi     (base_hi),
        .rx_ptr      (ptr[0]),
        .tx_ptr      (ptr[1]),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .buf_addr    (buf_addr),
        .buf_len     (buf_len),
        .tx_req      (tx_req),
        .tx_done     (tx_done),
        .tx_underrun (tx_underrun),
        .txdone_irq  (txdone_irq),
        .rx_req      (rx_req),
        .rx_done     (rx_done),
        .rx_count    (rx_count),
        .rx_overflow (rx_overflow),
        .rx_crc_err  (rx_crc_err),
        .rx_phy_err  (rx_phy_err),
        .rx_adv      (adv[0]),
        .tx_adv      (adv[1])
    );

    assign rx_slot = ptr[0];
    assign tx_slot = ptr[1];

    // R10: pointers only move right after a write-back
    a_r10_rx_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_slot) |-> $past(mem_wr));
    a_r10_tx_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_slot) |-> $past(mem_wr));
endmodule

// File: tb/ring_mgr_tb.sv
`timescale 1ns/1ps
module ring_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [5:0]  rx_slot, tx_slot;
    logic        mem_rd, mem_wr;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [31:0] buf_addr;
    logic [11:0] buf_len;
    logic        tx_req, tx_done, tx_underrun, txdone_irq;
    logic        rx_req, rx_done, rx_overflow, rx_crc_err, rx_phy_err;
    logic [15:0] rx_count;

    always #2.5 clk = ~clk;

    ring_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_slot(rx_slot), .tx_slot(tx_slot),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
        .buf_len(buf_len), .tx_req(tx_req), .tx_done(tx_done),
        .tx_underrun(tx_underrun), .txdone_irq(txdone_irq), .rx_req(rx_req),
        .rx_done(rx_done), .rx_count(rx_count), .rx_overflow(rx_overflow),
        .rx_crc_err(rx_crc_err), .rx_phy_err(rx_phy_err)
    );

    typedef struct { logic [29:0] addr; logic [31:0] data; } wb_t;
    typedef struct { logic [31:0] a; logic [11:0] l; } req_t;
    typedef struct { logic [15:0] cnt; logic ov; logic crc; logic phy; } rxr_t;

    wb_t  wb_rx_q[$], wb_tx_q[$];
    req_t req_rx_q[$], req_tx_q[$];
    rxr_t rx_resp_q[$];
    logic tx_resp_q[$];

    int checks = 0, errors = 0;
    int rd_count = 0, irq_seen = 0, exp_irq = 0;
    bit finished = 0;
    logic [31:0] base_addr;

    // memory model, one-cycle read latency
    bit [31:0]   mem [1024];
    logic        seed_we = 1'b0;
    logic [9:0]  seed_idx;
    logic [31:0] seed_data;
    always @(posedge clk) begin
        if (seed_we) mem[seed_idx] <= seed_data;
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic seed(input logic [29:0] w, input logic [31:0] d);
        @(negedge clk);
        seed_we = 1'b1; seed_idx = w[9:0]; seed_data = d;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        base_addr = b;
        cfg_write(3'd0, b[17:10]);
        cfg_write(3'd1, b[25:18]);
        cfg_write(3'd2, {2'b00, b[31:26]});
    endtask

    function automatic logic [29:0] rx_word(input int i);
        return 30'(base_addr >> 2) + 30'(2 * i);
    endfunction
    function automatic logic [29:0] tx_word(input int i);
        return 30'(base_addr >> 2) + 30'h80 + 30'(2 * i);
    endfunction

    // driver: seed an owned receive slot and push its expectations (R7)
    task automatic drv_rx(input int i, input logic [15:0] len, input logic [7:0] sp,
                          input logic [31:0] ba, input logic [15:0] cnt,
                          input logic ov, input logic crc, input logic phy);
        logic [7:0]  ctl;
        logic [11:0] l;
        seed(rx_word(i), {8'h80, sp, len});
        seed(rx_word(i) + 30'd1, ba);
        req_rx_q.push_back('{a: ba, l: len[11:0]});
        rx_resp_q.push_back('{cnt: cnt, ov: ov, crc: crc, phy: phy});
        ctl = {1'b0, phy, crc, (cnt > {4'h0, len[11:0]}), ov, 1'b0, 1'b1, 1'b0};
        l   = (cnt > 16'd4095) ? 12'hFFF : cnt[11:0];
        wb_rx_q.push_back('{addr: rx_word(i), data: {ctl, sp, 4'h0, l}});
    endtask

    // driver: seed an owned transmit slot and push its expectations (R8, R9)
    task automatic drv_tx(input int i, input logic [15:0] len, input logic [7:0] sp,
                          input logic [7:0] ctl, input logic [31:0] ba, input logic und);
        seed(tx_word(i), {ctl | 8'h80, sp, len});
        seed(tx_word(i) + 30'd1, ba);
        req_tx_q.push_back('{a: ba, l: len[11:0]});
        tx_resp_q.push_back(und);
        wb_tx_q.push_back('{addr: tx_word(i), data: {(ctl & 8'h7E) | {7'h0, und}, sp, len}});
        if (ctl[2]) exp_irq++;
    endtask

    // monitor: compare write-backs against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && mem_rd) rd_count++;
        if (rst_n && txdone_irq) irq_seen++;
        if (rst_n && mem_wr) begin
            wb_t e;
            if (mem_addr[7]) begin
                if (wb_tx_q.size() == 0) chk("R5 unexpected tx write-back", {2'b0, mem_addr}, 32'hFFFF_FFFF);
                else begin
                    e = wb_tx_q.pop_front();
                    chk("R3 tx write-back address", {2'b0, mem_addr}, {2'b0, e.addr});
                    chk("R8 tx write-back word", mem_wdata, e.data);
                end
            end else begin
                if (wb_rx_q.size() == 0) chk("R5 unexpected rx write-back", {2'b0, mem_addr}, 32'hFFFF_FFFF);
                else begin
                    e = wb_rx_q.pop_front();
                    chk("R3 rx write-back address", {2'b0, mem_addr}, {2'b0, e.addr});
                    chk("R7 rx write-back word", mem_wdata, e.data);
                end
            end
        end
    end

    // receive peer
    initial begin
        rx_done = 1'b0; rx_count = '0; rx_overflow = 1'b0; rx_crc_err = 1'b0; rx_phy_err = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_req) begin
                req_t q; rxr_t r;
                if (req_rx_q.size() == 0) chk("R5 unexpected rx request", 32'd1, 32'd0);
                else begin
                    q = req_rx_q.pop_front();
                    chk("R6 rx buf_addr", buf_addr, q.a);
                    chk("R6 rx buf_len", {20'h0, buf_len}, {20'h0, q.l});
                end
                repeat (3) @(negedge clk);
                chk("R6 rx_req held", {31'h0, rx_req}, 32'd1);
                r = (rx_resp_q.size() != 0) ? rx_resp_q.pop_front() : '{cnt: 16'h0, ov: 1'b0, crc: 1'b0, phy: 1'b0};
                rx_count = r.cnt; rx_overflow = r.ov; rx_crc_err = r.crc; rx_phy_err = r.phy;
                rx_done = 1'b1;
                @(negedge clk);
                rx_done = 1'b0;
            end
        end
    end

    // transmit peer
    initial begin
        tx_done = 1'b0; tx_underrun = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_req) begin
                req_t q;
                if (req_tx_q.size() == 0) chk("R5 unexpected tx request", 32'd1, 32'd0);
                else begin
                    q = req_tx_q.pop_front();
                    chk("R6 tx buf_addr", buf_addr, q.a);
                    chk("R6 tx buf_len", {20'h0, buf_len}, {20'h0, q.l});
                end
                repeat (2) @(negedge clk);
                chk("R6 tx_req held", {31'h0, tx_req}, 32'd1);
                tx_underrun = (tx_resp_q.size() != 0) ? tx_resp_q.pop_front() : 1'b0;
                tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0;
            end
        end
    end

    task automatic end_scan(input string name, input int rx_exp, input int tx_exp);
        repeat (300) @(negedge clk);
        chk({"R5 rx write-backs outstanding ", name}, wb_rx_q.size(), 0);
        chk({"R5 tx write-backs outstanding ", name}, wb_tx_q.size(), 0);
        chk({"R10 rx_slot after ", name}, {26'h0, rx_slot}, rx_exp);
        chk({"R10 tx_slot after ", name}, {26'h0, tx_slot}, tx_exp);
        chk({"R9 txdone_irq count after ", name}, irq_seen, exp_irq);
    endtask

    initial begin
        int r0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        chk("R1 rx_slot in reset", {26'h0, rx_slot}, 0);
        chk("R1 tx_slot in reset", {26'h0, tx_slot}, 0);
        chk("R1 memory strobes in reset", {30'h0, mem_rd, mem_wr}, 0);
        chk("R1 requests in reset", {29'h0, rx_req, tx_req, txdone_irq}, 0);
        rst_n = 1'b1;

        // scenario A: 4-slot rings, base 0x400
        set_base(32'h0000_0400);
        cfg_write(3'd3, 8'h00);
        drv_rx(0, 16'h1064, 8'h5A, 32'h1000_0000, 16'd100, 1'b0, 1'b0, 1'b0);
        drv_rx(1, 16'h0064, 8'hA5, 32'h1000_0800, 16'd5000, 1'b0, 1'b1, 1'b0);
        drv_tx(0, 16'hF03C, 8'h33, 8'h84, 32'h2000_0000, 1'b0);
        r0 = rd_count;
        cfg_write(3'd4, 8'hFE);
        repeat (20) @(negedge clk);
        chk("R2 prompt with bit0 clear: reads", rd_count - r0, 0);
        chk("R2 prompt with bit0 clear: rx_slot", {26'h0, rx_slot}, 0);
        cfg_write(3'd4, 8'h01);
        end_scan("A", 2, 1);

        // scenario B: receive wrap at 4 slots
        drv_rx(2, 16'h0100, 8'h11, 32'h1000_1000, 16'd50, 1'b1, 1'b0, 1'b1);
        drv_rx(3, 16'h0FFF, 8'h22, 32'h1000_1800, 16'd4095, 1'b0, 1'b0, 1'b0);
        drv_rx(0, 16'h000A, 8'h44, 32'h1000_2000, 16'd0, 1'b0, 1'b0, 1'b0);
        cfg_write(3'd4, 8'h01);
        end_scan("B R4 rx wrap at 4", 1, 1);

        // scenario C: transmit ring of 8 slots wrapping past slot 7
        cfg_write(3'd3, 8'h10);
        drv_tx(1, 16'h0010, 8'h01, 8'h80, 32'h2000_1000, 1'b1);
        drv_tx(2, 16'h0020, 8'h02, 8'h81, 32'h2000_2000, 1'b0);
        drv_tx(3, 16'h0030, 8'h03, 8'hFC, 32'h2000_3000, 1'b0);
        drv_tx(4, 16'h0040, 8'h04, 8'h80, 32'h2000_4000, 1'b1);
        drv_tx(5, 16'h0050, 8'h05, 8'h84, 32'h2000_5000, 1'b0);
        drv_tx(6, 16'h0060, 8'h06, 8'hC0, 32'h2000_6000, 1'b0);
        drv_tx(7, 16'h0070, 8'h07, 8'h80, 32'h2000_7000, 1'b0);
        drv_tx(0, 16'h0080, 8'h08, 8'h84, 32'h2000_8000, 1'b1);
        cfg_write(3'd4, 8'h01);
        end_scan("C R4 tx wrap at 8", 1, 1);

        // scenario D: upper base bits, mixed work on both rings
        set_base(32'hABCD_0400);
        cfg_write(3'd3, 8'hF1);
        drv_rx(1, 16'h0200, 8'h77, 32'h3000_0000, 16'd10, 1'b0, 1'b0, 1'b0);
        drv_rx(2, 16'h0200, 8'h78, 32'h3000_0400, 16'd600, 1'b1, 1'b1, 1'b1);
        drv_tx(1, 16'h0123, 8'h99, 8'h86, 32'h4000_0000, 1'b0);
        cfg_write(3'd4, 8'h01);
        end_scan("D R3 high base", 3, 2);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule